// File: doc/BRIEF.md
# Translation Shootdown Coordinator

This block sequences the removal of one stale address translation from every core of a multicore cluster after a page permission change. A core asks for a shootdown by giving its own core index, the virtual page number and a bitmask of the cores that might hold the translation. The mask may name more cores than needed, but it must never leave out a core that holds the translation.

The coordinator first asks for the lock on the page table entry and waits for the grant. Once it holds the lock, it raises an invalidate interrupt toward every listed core other than the initiator. In the same cycle it pulses a local invalidate for the initiator. It then tracks a pending bit per remote core. Each bit drops when that core acknowledges. When no bit remains, the coordinator releases the lock and pulses done.

Acknowledgements may take thousands of cycles, and the wait has no limit. An acknowledgement that matches no pending bit changes nothing and raises a one-cycle stray flag.

Top module: `shootdown_engine`

## Requirements
- R1: During and after reset, `busy`, `lock_req`, `inv_req`, `local_inv`, `done` and `stray_ack` are all low.
- R2: A `req_valid` sampled at a clock edge while idle starts an operation. From the next cycle `busy` and `lock_req` are high, and `inv_vpn` and `local_core` hold the requested page and initiator index.
- R3: Before `lock_grant` has been sampled high, neither `inv_req` nor `local_inv` is asserted. Whenever either of them is high, `lock_req` is high too.
- R4: In the cycle after the grant is sampled, `inv_req` shows the target mask with the initiator's bit cleared (bit i addresses core i). Each bit stays high until an acknowledgement on `ack[i]` is sampled, and drops in the following cycle.
- R5: `local_inv` is high for exactly one cycle: the cycle after the grant is sampled.
- R6: The initiator's own bit in the target mask never produces an interrupt on `inv_req`.
- R7: `lock_req` falls in the cycle after the last pending acknowledgement is sampled. `done` is high for exactly that one cycle, and `busy` falls with it.
- R8: If no core other than the initiator is targeted, `done` rises and `lock_req` falls in the cycle right after the `local_inv` pulse.
- R9: A `req_valid` sampled while `busy` is high is refused. It does not alter `inv_vpn` or `local_core`, and it does not start a second operation.
- R10: An `ack[i]` sampled while bit i is not pending leaves `inv_req` unchanged and raises `stray_ack` for the following cycle. This includes an ack while idle and an ack from the initiator itself.
- R11: An acknowledgement sampled in the same cycle as `local_inv` clears its pending bit and can complete the operation.
- R12: Any acknowledgement latency is accepted. `lock_req` and the pending interrupts hold for as long as an acknowledgement is missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Shootdown request strobe |
| req_core | input | CID_W | Index of the initiating core |
| req_vpn | input | VPN_W | Virtual page number to invalidate |
| req_targets | input | NCORES | Conservative mask of cores that may hold the translation |
| lock_grant | input | 1 | Page table entry lock granted |
| ack | input | NCORES | Per-core invalidate acknowledgement |
| busy | output | 1 | Operation in progress; new requests are refused |
| lock_req | output | 1 | Lock held or requested; falling edge releases it |
| inv_req | output | NCORES | Per-core invalidate interrupt, held until acknowledged |
| inv_vpn | output | VPN_W | Page number carried with the invalidates |
| local_inv | output | 1 | One-cycle local invalidate for the initiator |
| local_core | output | CID_W | Initiator index of the current operation |
| done | output | 1 | One-cycle pulse at lock release |
| stray_ack | output | 1 | One-cycle flag for an ack with no pending bit |

## Verification
Two things can land in the same cycle: the local invalidate pulse and the arrival of remote acknowledgements. The bench provokes this by holding the grant high in advance and raising every acknowledgement, including the initiator's own, as soon as `local_inv` is seen. In the next cycle it expects `done`, lock release and `stray_ack` together. The per-operation interrupt mask, page and initiator are queued when each request is driven and compared when `local_inv` appears. A refused request arriving in the middle of an operation must leave no trace in the queued expectations.

// File: rtl/shootdown_engine.sv
module shootdown_engine #(
  parameter int NCORES = 4,
  parameter int VPN_W  = 20,
  localparam int CID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CID_W-1:0]  req_core,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [NCORES-1:0] req_targets,
  input  logic              lock_grant,
  input  logic [NCORES-1:0] ack,
  output logic              busy,
  output logic              lock_req,
  output logic [NCORES-1:0] inv_req,
  output logic [VPN_W-1:0]  inv_vpn,
  output logic              local_inv,
  output logic [CID_W-1:0]  local_core,
  output logic              done,
  output logic              stray_ack
);

  typedef enum logic [1:0] {S_IDLE, S_LOCK, S_LOCAL, S_WAIT} state_t;

  state_t            state;
  logic [NCORES-1:0] targets_q;
  logic [NCORES-1:0] pending;
  logic [NCORES-1:0] self_oh;
  logic [NCORES-1:0] pending_nx;

  assign self_oh    = {{(NCORES-1){1'b0}}, 1'b1} << local_core;
  assign pending_nx = pending & ~ack;

  assign busy      = (state != S_IDLE);
  assign lock_req  = busy;
  assign local_inv = (state == S_LOCAL);
  assign inv_req   = pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      targets_q  <= '0;
      pending    <= '0;
      inv_vpn    <= '0;
      local_core <= '0;
      done       <= 1'b0;
      stray_ack  <= 1'b0;
    end else begin
      done      <= 1'b0;
      stray_ack <= |(ack & ~pending);
      pending   <= pending_nx;
      case (state)
        S_IDLE: if (req_valid) begin
          inv_vpn    <= req_vpn;
          local_core <= req_core;
          targets_q  <= req_targets;
          state      <= S_LOCK;
        end
        S_LOCK: if (lock_grant) begin
          pending <= targets_q & ~self_oh;
          state   <= S_LOCAL;
        end
        S_LOCAL: begin
          if (pending_nx == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (pending_nx == '0) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shootdown_engine_checks.sv
module shootdown_engine_checks #(
  parameter int NCORES = 4,
  parameter int VPN_W  = 20,
  localparam int CID_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] ack,
  input logic              busy,
  input logic              lock_req,
  input logic [NCORES-1:0] inv_req,
  input logic [VPN_W-1:0]  inv_vpn,
  input logic              local_inv,
  input logic [CID_W-1:0]  local_core,
  input logic              done,
  input logic              stray_ack
);

  p_inv_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_req || local_inv) |-> lock_req);

  p_no_self_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !inv_req[local_core]);

  p_local_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    local_inv |=> !local_inv);

  p_ack_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |(inv_req & ack) |=> ((inv_req & $past(inv_req & ack)) == '0));

  p_unlock_after_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_req) |-> (inv_req == '0) && done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(inv_vpn) && $stable(local_core)));

  p_idle_ack_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && |ack) |=> stray_ack);

endmodule

bind shootdown_engine shootdown_engine_checks #(.NCORES(NCORES), .VPN_W(VPN_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .ack(ack), .busy(busy), .lock_req(lock_req),
  .inv_req(inv_req), .inv_vpn(inv_vpn), .local_inv(local_inv),
  .local_core(local_core), .done(done), .stray_ack(stray_ack)
);

// File: tb/shootdown_engine_test.sv
module shootdown_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int VW = 20;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_core = '0;
  logic [VW-1:0] req_vpn = '0;
  logic [NC-1:0] req_targets = '0;
  logic          lock_grant = 1'b0;
  logic [NC-1:0] ack = '0;
  logic          busy, lock_req, local_inv, done, stray_ack;
  logic [NC-1:0] inv_req;
  logic [VW-1:0] inv_vpn;
  logic [CW-1:0] local_core;

  int nchk = 0;
  int nfail = 0;

  typedef struct packed {
    logic [VW-1:0] vpn;
    logic [CW-1:0] core;
    logic [NC-1:0] mask;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shootdown_engine #(.NCORES(NC), .VPN_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_vpn(req_vpn), .req_targets(req_targets), .lock_grant(lock_grant),
    .ack(ack), .busy(busy), .lock_req(lock_req), .inv_req(inv_req),
    .inv_vpn(inv_vpn), .local_inv(local_inv), .local_core(local_core),
    .done(done), .stray_ack(stray_ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // driver: push the expected local-invalidate item, then present the request for one cycle
  task automatic shoot(input logic [CW-1:0] c, input logic [VW-1:0] v, input logic [NC-1:0] t);
    exp_t e;
    e.vpn = v; e.core = c; e.mask = t & ~(NC'(1) << c);
    expq.push_back(e);
    req_valid = 1'b1; req_core = c; req_vpn = v; req_targets = t;
    tick();
    req_valid = 1'b0;
  endtask

  // monitor: compare each local invalidate with the queued expectation (R4, R5, R6)
  always @(negedge clk) begin
    if (rst_n && local_inv) begin
      if (expq.size() == 0) begin
        check(1'b0, "R5 unexpected local_inv", 32'(local_inv), 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(inv_req == e.mask, "R4/R6 inv_req mask", 32'(inv_req), 32'(e.mask));
        check(inv_vpn == e.vpn, "R4 inv_vpn", 32'(inv_vpn), 32'(e.vpn));
        check(local_core == e.core, "R5 local_core", 32'(local_core), 32'(e.core));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    tick(3);
    check({busy, lock_req, local_inv, done, stray_ack} == 5'b0 && inv_req == '0,
          "R1 reset outputs", {busy, lock_req, local_inv, done, stray_ack}, 32'd0);
    rst_n = 1'b1;
    tick();
    check(!busy && !lock_req, "R1 idle after reset", {busy, lock_req}, 32'd0);

    // A: core 0, targets 1011, grant delayed, refused request while busy, long ack wait
    shoot(2'd0, 20'h12345, 4'b1011);
    check(busy && lock_req, "R2 busy and lock_req", {busy, lock_req}, 32'd3);
    check(inv_vpn == 20'h12345 && local_core == 2'd0, "R2 captured vpn", 32'(inv_vpn), 32'h12345);
    req_valid = 1'b1; req_core = 2'd3; req_vpn = 20'h0BEEF; req_targets = 4'b1111;
    tick();
    req_valid = 1'b0;
    check(inv_req == '0 && !local_inv, "R3 nothing before grant", {inv_req, local_inv}, 32'd0);
    check(inv_vpn == 20'h12345 && local_core == 2'd0, "R9 refused request", 32'(inv_vpn), 32'h12345);
    tick(2);
    check(inv_req == '0 && !local_inv && lock_req, "R3 still waiting for grant", {inv_req, local_inv}, 32'd0);
    lock_grant = 1'b1;
    tick();
    lock_grant = 1'b0;
    check(local_inv, "R5 local_inv after grant", 32'(local_inv), 32'd1);
    tick();
    check(!local_inv && inv_req == 4'b1010, "R5 single pulse", {local_inv, inv_req}, 32'h0a);
    tick(500);
    check(lock_req && inv_req == 4'b1010 && !done, "R12 long wait holds", {lock_req, inv_req}, 32'h1a);
    ack = 4'b0010;
    tick();
    ack = '0;
    check(inv_req == 4'b1000 && lock_req, "R4 ack drops bit", 32'(inv_req), 32'h8);
    ack = 4'b0100;
    tick();
    ack = '0;
    check(stray_ack && inv_req == 4'b1000, "R10 stray ack while busy", {stray_ack, inv_req}, 32'h18);
    tick(20);
    ack = 4'b1000;
    tick();
    ack = '0;
    check(done && !lock_req && !busy && inv_req == '0, "R7 release after last ack", {done, lock_req, busy}, 32'h4);
    tick();
    check(!done && !busy, "R7/R9 done pulse, no second op", {done, busy}, 32'd0);

    // B: only the initiator targeted
    lock_grant = 1'b1;
    shoot(2'd2, 20'h00777, 4'b0100);
    tick();
    check(local_inv && inv_req == '0, "R8 local only", {local_inv, inv_req}, 32'h10);
    tick();
    check(done && !lock_req, "R8 skip wait", {done, lock_req}, 32'h2);
    tick();

    // C: acks (plus initiator's own) in the local_inv cycle
    shoot(2'd1, 20'hABCDE, 4'b1101);
    tick();
    check(local_inv, "R11 local_inv cycle", 32'(local_inv), 32'd1);
    ack = 4'b1111;
    tick();
    ack = '0;
    check(done && !lock_req && stray_ack, "R11 same-cycle acks finish", {done, lock_req, stray_ack}, 32'h5);
    lock_grant = 1'b0;
    tick();

    // D: ack while idle
    ack = 4'b0001;
    tick();
    ack = '0;
    check(stray_ack && !busy && inv_req == '0, "R10 idle ack", {stray_ack, busy}, 32'h2);
    tick();
    check(!stray_ack, "R10 flag is one cycle", 32'(stray_ack), 32'd0);
    check(expq.size() == 0, "R4 all expected invalidates seen", expq.size(), 32'd0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule